// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a relative-time alarm. Software loads a number of seconds, turns counting on, and the block steps that number down by one on every 1 Hz tick it sees. When the count goes from one to zero, a sticky pending flag is raised. The flag stays up until software clears it by writing a one to it. Two outputs come from that flag: an interrupt line gated by an interrupt-enable bit, and a wakeup line gated by a separate wakeup-enable bit.

Software reaches the block through a simple single-cycle register port. A write takes effect at the clock edge where it is presented, and reads are returned combinationally for the address on the port. Three registers for a calendar alarm are kept only as stubs: two enable bits that store and read back, and a status register that never becomes pending.

Register map (byte offsets; only bit 0 is meaningful unless stated):
0x20 load (full count width), 0x24 remaining count (read only), 0x28 count enable, 0x2C interrupt enable, 0x30 pending (write 1 to clear), 0x44 calendar enable stub, 0x48 calendar interrupt-enable stub, 0x4C calendar status stub (reads 0), 0x50 wakeup enable.

Top module: `countdown_alarm`

## Requirements
- R1: After reset, every register reads 0 and both irq_o and wake_o are low.
- R2: A write to 0x20 sets the remaining count (read at 0x24) and the load register (read at 0x20) to the written value at that clock edge; writing 0 clears a loaded count.
- R3: A tick decrements the remaining count by one only while bit 0 of 0x28 is 1 and the count is non-zero; otherwise the count holds.
- R4: The tick that takes the count from 1 to 0 sets the pending flag (bit 0 of 0x30) at the same edge; ticks at a count of 0 never set it.
- R5: The pending flag stays set until a write to 0x30 with bit 0 = 1; a write with bit 0 = 0 leaves it unchanged.
- R6: When a clearing write to 0x30 and an expiry happen at the same edge, the pending flag ends up set.
- R7: irq_o is high exactly when the pending flag and bit 0 of 0x2C are both 1.
- R8: wake_o is high exactly when the pending flag and bit 0 of 0x50 are both 1.
- R9: A load write at the same edge as a tick wins: the count takes the written value and no expiry occurs.
- R10: Bit 0 of 0x44 and 0x48 store and read back; 0x4C always reads 0 and writes to these three registers change neither irq_o nor wake_o.
- R11: Unmapped addresses read 0, writes to 0x24 are ignored, and bits above bit 0 of the single-bit registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset for read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
Every result is due at the clock edge that samples the stimulus: a write, a tick or a clear is visible on the count readback, the pending bit, irq_o and wake_o one nanosecond after that edge, with no extra pipeline stage. The bench drives inputs between edges, advances its reference model once per edge from the pre-edge state, and compares immediately after the edge while holding write and tick low, so each compare sees exactly one edge's worth of change. Same-edge collisions (load against tick, clear against expiry) are driven as single cycles so the priority rules are checked at the edge they apply.

// File: rtl/cda_pkg.sv
// Package: register offsets and shared constants for the countdown alarm.
// Assumes byte offsets fit in 8 bits; callers cast to their address width.
package cda_pkg;
    localparam int OFF_LOAD     = 'h20;
    localparam int OFF_REMAIN   = 'h24;
    localparam int OFF_CNT_EN   = 'h28;
    localparam int OFF_IRQ_EN   = 'h2C;
    localparam int OFF_PEND     = 'h30;
    localparam int OFF_CAL_EN   = 'h44;
    localparam int OFF_CAL_IE   = 'h48;
    localparam int OFF_CAL_STAT = 'h4C;
    localparam int OFF_WAKE_EN  = 'h50;

    // Single-bit control registers, in the order the enable vector uses.
    localparam int NUM_CTL = 5;
    localparam int CTL_CNT  = 0;
    localparam int CTL_IRQ  = 1;
    localparam int CTL_WAKE = 2;
    localparam int CTL_CAL  = 3;
    localparam int CTL_CALI = 4;
    localparam int CTL_OFFS [NUM_CTL] = '{OFF_CNT_EN, OFF_IRQ_EN, OFF_WAKE_EN,
                                          OFF_CAL_EN, OFF_CAL_IE};
endpackage

// File: rtl/cda_ctrl_regs.sv
// Module: write decode and storage for the alarm's control registers.
// Holds the single-bit enables and the load register, and produces the
// load strobe and the write-one-to-clear strobes. Assumes one write per cycle.
module cda_ctrl_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [cda_pkg::NUM_CTL-1:0] ctl_o,
    output logic [CNT_W-1:0]      load_q_o,
    output logic                  load_wr_o,
    output logic                  pend_clr_o,
    output logic                  cal_clr_o
);
    import cda_pkg::*;

    // Strobes: decoded writes that act in the same cycle.
    always_comb begin
        load_wr_o  = wr_i && (addr_i == ADDR_W'(OFF_LOAD));
        pend_clr_o = wr_i && (addr_i == ADDR_W'(OFF_PEND)) && wdata_i[0];
        cal_clr_o  = wr_i && (addr_i == ADDR_W'(OFF_CAL_STAT)) && wdata_i[0];
    end

    // One flop per single-bit control register, selected by its offset.
    for (genvar g = 0; g < NUM_CTL; g++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_o[g] <= 1'b0;
            else if (wr_i && (addr_i == ADDR_W'(CTL_OFFS[g])))
                ctl_o[g] <= wdata_i[0];
        end
    end

    // Load register: keeps the last value written for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_q_o <= '0;
        else if (load_wr_o)
            load_q_o <= wdata_i[CNT_W-1:0];
    end
endmodule

// File: rtl/cda_counter.sv
// Module: seconds down-counter. A load write replaces the count and beats a
// tick in the same cycle. While enabled, a tick steps a non-zero count down;
// the step from 1 to 0 produces a one-cycle expiry strobe.
// Assumes tick_i is a single-cycle pulse.
module cda_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic step;

    // Decide whether this cycle counts down and whether it expires.
    always_comb begin
        step     = tick_i && en_i && (cnt_o != '0) && !load_wr_i;
        expire_o = step && (cnt_o == ONE);
    end

    // Count register: load has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (load_wr_i)
            cnt_o <= load_val_i;
        else if (step)
            cnt_o <= cnt_o - ONE;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> cnt_o == $past(load_val_i)); // R9
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_wr_i) |=> $stable(cnt_o)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && en_i && !load_wr_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - ONE); // R3
endmodule

// File: rtl/cda_pending.sv
// Module: sticky pending flag with write-one-to-clear. A set in the same
// cycle as a clear wins, so no expiry can be lost.
module cda_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // Flag register: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else
            pend_o <= (pend_o && !clr_i) || set_i;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o); // R6
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o); // R5
    AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o); // R5
endmodule

// File: rtl/countdown_alarm.sv
// Module: top of the seconds countdown alarm. Ties the control registers,
// the down-counter and the pending flags together, drives the gated
// interrupt and wakeup outputs and the combinational read mux.
// Assumes DATA_W >= CNT_W and a single-cycle tick pulse.
module countdown_alarm #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);
    import cda_pkg::*;

    logic [NUM_CTL-1:0] ctl;
    logic [CNT_W-1:0]   load_q;
    logic [CNT_W-1:0]   cnt;
    logic               load_wr, pend_clr, cal_clr, expire;
    logic               pend, cal_pend;

    cda_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .ctl_o      (ctl),
        .load_q_o   (load_q),
        .load_wr_o  (load_wr),
        .pend_clr_o (pend_clr),
        .cal_clr_o  (cal_clr)
    );

    cda_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .en_i       (ctl[CTL_CNT]),
        .load_wr_i  (load_wr),
        .load_val_i (reg_wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    cda_pending i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expire),
        .clr_i  (pend_clr),
        .pend_o (pend)
    );

    // Calendar alarm status stub: nothing sets it, so it stays clear.
    cda_pending i_cal_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (1'b0),
        .clr_i  (cal_clr),
        .pend_o (cal_pend)
    );

    // Output gating: each line is the pending flag under its own enable.
    always_comb begin
        irq_o  = pend && ctl[CTL_IRQ];
        wake_o = pend && ctl[CTL_WAKE];
    end

    // Read mux: single-bit registers sit in bit 0, the rest reads zero.
    always_comb begin
        reg_rdata_o = '0;
        case (int'(reg_addr_i))
            OFF_LOAD:     reg_rdata_o = DATA_W'(load_q);
            OFF_REMAIN:   reg_rdata_o = DATA_W'(cnt);
            OFF_CNT_EN:   reg_rdata_o[0] = ctl[CTL_CNT];
            OFF_IRQ_EN:   reg_rdata_o[0] = ctl[CTL_IRQ];
            OFF_PEND:     reg_rdata_o[0] = pend;
            OFF_CAL_EN:   reg_rdata_o[0] = ctl[CTL_CAL];
            OFF_CAL_IE:   reg_rdata_o[0] = ctl[CTL_CALI];
            OFF_CAL_STAT: reg_rdata_o[0] = cal_pend;
            OFF_WAKE_EN:  reg_rdata_o[0] = ctl[CTL_WAKE];
            default:      reg_rdata_o = '0;
        endcase
    end

    AST_EXPIRY_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ctl[CTL_CNT] && !load_wr && cnt == CNT_W'(1)) |=> pend); // R4
    AST_CAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_pend); // R10
endmodule

// File: tb/test_countdown_alarm.sv
// Bench: reference model of the alarm, random register traffic with ticks,
// plus directed collision and boundary cases.
module test_countdown_alarm;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, wake;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [DW-1:0] m_cnt, m_load;
    bit m_en, m_ie, m_we, m_cen, m_cie, m_pend;

    countdown_alarm #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(DW)) i_countdown_alarm (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reg_wr_i(reg_wr_q()),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .irq_o(irq), .wake_o(wake)
    );

    function automatic logic reg_wr_q();
        return wr;
    endfunction

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        case (int'(a))
            'h20: return m_load;
            'h24: return m_cnt;
            'h28: return DW'(m_en);
            'h2C: return DW'(m_ie);
            'h30: return DW'(m_pend);
            'h44: return DW'(m_cen);
            'h48: return DW'(m_cie);
            'h50: return DW'(m_we);
            default: return '0;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = '0; m_load = '0; m_en = 0; m_ie = 0; m_we = 0;
        m_cen = 0; m_cie = 0; m_pend = 0;
    endtask

    // Advance the model by one edge, from the pre-edge state.
    task automatic model_step(input bit w, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input bit t);
        bit ld, stp, ex, clr;
        ld  = w && a == AW'('h20);
        stp = t && m_en && m_cnt != 0 && !ld;
        ex  = stp && m_cnt == 1;
        clr = w && a == AW'('h30) && d[0];
        if (stp) m_cnt = m_cnt - 1;
        if (w) begin
            case (int'(a))
                'h20: begin m_cnt = d; m_load = d; end
                'h28: m_en  = d[0];
                'h2C: m_ie  = d[0];
                'h44: m_cen = d[0];
                'h48: m_cie = d[0];
                'h50: m_we  = d[0];
                default: ;
            endcase
        end
        m_pend = (m_pend && !clr) || ex;
    endtask

    // One clock: drive between edges, update model, settle after the edge.
    task automatic cyc(input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input bit t);
        wr = w; addr = a; wdata = d; tick = t;
        @(posedge clk);
        model_step(w, a, d, t);
        #1;
        wr = 1'b0; tick = 1'b0;
    endtask

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reg(input string req, input logic [AW-1:0] a);
        addr = a;
        #1;
        check(req, $sformatf("read 0x%0h", a), rdata, exp_read(a));
    endtask

    task automatic check_outs(input string req);
        check(req, "irq_o",  DW'(irq),  DW'(m_pend && m_ie));
        check(req, "wake_o", DW'(wake), DW'(m_pend && m_we));
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] addrs [10];
        addrs = '{AW'('h20), AW'('h24), AW'('h28), AW'('h2C), AW'('h30),
                  AW'('h44), AW'('h48), AW'('h4C), AW'('h50), AW'('h10)};
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state of every register and both outputs
        for (int i = 0; i < 10; i++) check_reg("R1", addrs[i]);
        check_outs("R1");

        // R2: load then clear by writing zero
        cyc(1, AW'('h20), 32'd9, 0);
        check_reg("R2", AW'('h24));
        check_reg("R2", AW'('h20));
        cyc(1, AW'('h20), 32'd0, 0);
        check_reg("R2", AW'('h24));

        // R3: disabled ticks hold the count
        cyc(1, AW'('h20), 32'd2, 0);
        cyc(0, '0, '0, 1);
        check_reg("R3", AW'('h24));

        // R4, R7, R8: expiry with both gates open
        cyc(1, AW'('h2C), 32'd1, 0);
        cyc(1, AW'('h50), 32'd1, 0);
        cyc(1, AW'('h28), 32'd1, 0);
        cyc(0, '0, '0, 1);
        check_reg("R3", AW'('h24));
        check_reg("R4", AW'('h30));
        cyc(0, '0, '0, 1);
        check_reg("R4", AW'('h30));
        check_outs("R7");
        check_outs("R8");
        // R4: ticks at zero do not retrigger after a clear
        cyc(1, AW'('h30), 32'd1, 0);
        cyc(0, '0, '0, 1);
        check_reg("R4", AW'('h30));
        check_reg("R4", AW'('h24));

        // R5: writing 0 to status keeps a pending flag
        cyc(1, AW'('h20), 32'd1, 0);
        cyc(0, '0, '0, 1);
        cyc(1, AW'('h30), 32'hFFFF_FFFE, 0);
        check_reg("R5", AW'('h30));
        check_outs("R5");

        // R6: clear and expiry on the same edge
        cyc(1, AW'('h30), 32'd1, 0);
        cyc(1, AW'('h20), 32'd1, 0);
        cyc(1, AW'('h30), 32'd1, 1);
        check_reg("R6", AW'('h30));
        check_outs("R6");
        cyc(1, AW'('h30), 32'd1, 0);
        check_reg("R6", AW'('h30));

        // R9: load beats a tick on the same edge
        cyc(1, AW'('h20), 32'd1, 0);
        cyc(1, AW'('h20), 32'd7, 1);
        check_reg("R9", AW'('h24));
        check_reg("R9", AW'('h30));

        // R10: calendar stubs store and stay quiet
        cyc(1, AW'('h44), 32'd1, 0);
        cyc(1, AW'('h48), 32'd1, 0);
        cyc(1, AW'('h4C), 32'hFFFF_FFFF, 0);
        check_reg("R10", AW'('h44));
        check_reg("R10", AW'('h48));
        check_reg("R10", AW'('h4C));
        check_outs("R10");

        // R11: readonly and upper bits
        cyc(1, AW'('h24), 32'd99, 0);
        check_reg("R11", AW'('h24));
        cyc(1, AW'('h2C), 32'hFFFF_FFFF, 0);
        check_reg("R11", AW'('h2C));
        check_reg("R11", AW'('h10));

        // Random traffic against the model (R2 to R11)
        for (int k = 0; k < 4000; k++) begin
            bit w, t;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            w = ($urandom % 3) == 0;
            t = ($urandom % 2) == 0;
            a = addrs[$urandom % 10];
            d = (a == AW'('h20)) ? DW'($urandom % 6) : DW'($urandom);
            if (a == AW'('h30) && ($urandom % 4) != 0) d = '0;
            cyc(w, a, d, t);
            check_reg("R3", AW'('h24));
            check_reg("R5", AW'('h30));
            check_reg("R11", addrs[$urandom % 10]);
            check_outs("R7");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule